// File: doc/BRIEF.md
# Prescaled 8-bit Interval Timer

This block is an 8-bit up-counter that advances on count strobes taken from a free-running 11-bit divider of the system clock. Three divider taps are selectable: one strobe every 8, 128 or 2048 system clocks. A fourth select code stops the strobes. The counter restarts from zero each time it completes the programmed number of counts. On each completion it emits a one-cycle interrupt pulse, and it can also invert a toggle flip-flop. The flip-flop drives an output pin, which then carries a square wave with 50% duty whose half period is the match interval.

The interrupt output is one line shared between the timer and an external converter-done request. A routing flag picks which of the two reaches the line; the other is blocked. The flip-flop can be forced to zero, and inversion on match can be enabled or disabled. A run input starts and stops the counter. Stopping also clears the count.

The counting control is a two-state machine. In STOP the count is held at zero; the transition RUN_START is taken when the run input is high. In RUN the counter advances on each strobe; the transition HALT back to STOP is taken when the run input is low. Inside RUN, a strobe on which the count would reach the programmed value takes the WRAP action: the count returns to zero and a match pulse is issued.

Top module: `ivtmr_top`

## Requirements
- R1: With `run` low the count is forced to zero on the next clock and stays there. After `run` goes high again, counting starts from zero, and the first match comes within one strobe period of value × divide clocks.
- R2: `clk_sel` codes: 0 gives one strobe per 8 system clocks, 1 gives one per 128, 2 gives one per 2048, and 3 gives no strobes, so the count holds at zero while running.
- R3: With `irq_sel` = 0 and `match_val` = N (1..255), `irq_out` pulses once every N × divide system clocks. For example, N = 50 at divide-by-8 gives 400 clocks.
- R4: `match_val` = 0 is treated as 256 counts: one pulse every 256 × divide clocks.
- R5: Each timer match appears on `irq_out` as a pulse exactly one system clock wide.
- R6: With `irq_sel` = 1, a `cnv_req` pulse appears on `irq_out` one clock later and timer matches are blocked. With `irq_sel` = 0, `cnv_req` is blocked.
- R7: With `ff_inv_en` = 1, the flip-flop inverts on every match and `tmr_out` carries it. This gives equal high and low times of N × divide clocks; N = 3 at divide-by-8 gives 24 clocks each.
- R8: A one-cycle `ff_clr` forces the flip-flop to 0, and `tmr_out` is 0 two clocks after `ff_clr` is sampled. A clear that lands on the same clock as a match wins over the inversion.
- R9: With `ff_inv_en` = 0 and no clear, `tmr_out` does not change across matches.
- R10: During reset, `cnt_out`, `irq_out` and `tmr_out` are 0.
- R11: While running with a fixed `match_val` = N, `cnt_out` takes values 0 to N-1; its largest value is N-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | 1 = count, 0 = stop and clear the count |
| clk_sel | input | 2 | Count strobe source: 0 = /8, 1 = /128, 2 = /2048, 3 = none |
| match_val | input | 8 | Match value; 0 means 256 |
| ff_clr | input | 1 | Force the toggle flip-flop to 0 |
| ff_inv_en | input | 1 | Invert the flip-flop on each match |
| irq_sel | input | 1 | 0 = timer drives `irq_out`, 1 = converter request drives it |
| cnv_req | input | 1 | Converter-done request pulse |
| irq_out | output | 1 | Shared interrupt request line |
| tmr_out | output | 1 | Registered flip-flop state for the output pin |
| cnt_out | output | 8 | Current count |

## Verification
The hardest case to reach from the ports is a flip-flop clear that falls on exactly the same clock as a match, because the match instant depends on the free-running divider phase and cannot be seen directly. The bench sets a match value of 1 at divide-by-8 so that matches recur every 8 clocks, and it locks onto the phase from an `irq_out` pulse. It then places `ff_clr` on the clock of the next match, with the flip-flop known to be 0, so that a wrong priority would show as a 1 on `tmr_out`. Long intervals at divide-by-2048 and the 256-count case are reached by restarting from a stopped state, so no earlier count can push the counter past its match value.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

    // Counting control states
    typedef enum logic [0:0] {
        ST_STOP = 1'b0,
        ST_RUN  = 1'b1
    } tmr_state_t;

    // Strobe source select encoding
    localparam int SEL_W = 2;
    localparam logic [SEL_W-1:0] SEL_DIV8    = 2'd0;
    localparam logic [SEL_W-1:0] SEL_DIV128  = 2'd1;
    localparam logic [SEL_W-1:0] SEL_DIV2048 = 2'd2;
    localparam logic [SEL_W-1:0] SEL_NONE    = 2'd3;

    // Interrupt routing encoding
    localparam logic ROUTE_TIMER = 1'b0;
    localparam logic ROUTE_CONV  = 1'b1;

endpackage

// File: rtl/ivt_prescaler.sv
module ivt_prescaler
    import ivt_pkg::*;
#(
    parameter int PRE_W = 11,
    parameter int TAP0  = 3,
    parameter int TAP1  = 7,
    parameter int TAP2  = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int NTAP = 3;
    localparam int TAPS [NTAP] = '{TAP0, TAP1, TAP2};

    logic [PRE_W-1:0] pre_q;
    logic [NTAP-1:0]  hit;
    logic             sel_hit;
    logic             tick_q;

    // Free-running divider
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_q + 1'b1;
    end

    // A tap is about to rise when all bits below it are ones
    generate
        for (genvar g = 0; g < NTAP; g++) begin : g_tap
            assign hit[g] = &pre_q[TAPS[g]-1:0];
        end
    endgenerate

    always_comb begin
        sel_hit = 1'b0;
        for (int i = 0; i < NTAP; i++) begin
            if (sel == SEL_W'(i)) sel_hit = hit[i];
        end
    end

    // Strobe is registered so it coincides with the tap's rising transition
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tick_q <= 1'b0;
        else        tick_q <= sel_hit;
    end

    assign tick = tick_q;

endmodule

// File: rtl/ivt_count_fsm.sv
module ivt_count_fsm
    import ivt_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] cnt,
    output logic             match
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    tmr_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
    logic             match_q, match_d;

    assign cnt_inc = cnt_q + ONE;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STOP;
        else        state_q <= state_d;
    end

    // Next state and datapath outputs
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        match_d = 1'b0;
        unique case (state_q)
            ST_STOP: begin
                cnt_d = '0;
                if (run) state_d = ST_RUN;           // RUN_START
            end
            ST_RUN: begin
                if (!run) begin                       // HALT
                    state_d = ST_STOP;
                    cnt_d   = '0;
                end else if (tick) begin
                    if (cnt_inc == limit) begin       // WRAP (limit 0 wraps at 256)
                        cnt_d   = '0;
                        match_d = 1'b1;
                    end else begin
                        cnt_d = cnt_inc;
                    end
                end
            end
            default: state_d = ST_STOP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            match_q <= 1'b0;
        end else begin
            cnt_q   <= cnt_d;
            match_q <= match_d;
        end
    end

    assign cnt   = cnt_q;
    assign match = match_q;

endmodule

// File: rtl/ivt_toggle_ff.sv
module ivt_toggle_ff (
    input  logic clk,
    input  logic rst_n,
    input  logic match,
    input  logic clr,
    input  logic inv_en,
    output logic pin
);
    logic tff_q, pin_q;

    // Clear has priority over inversion
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               tff_q <= 1'b0;
        else if (clr)             tff_q <= 1'b0;
        else if (match && inv_en) tff_q <= ~tff_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_q <= 1'b0;
        else        pin_q <= tff_q;
    end

    assign pin = pin_q;

endmodule

// File: rtl/ivt_irq_route.sv
module ivt_irq_route
    import ivt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic route,
    input  logic tmr_match,
    input  logic conv_req,
    output logic irq
);
    logic irq_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  irq_q <= 1'b0;
        else if (route == ROUTE_CONV) irq_q <= conv_req;
        else                         irq_q <= tmr_match;
    end

    assign irq = irq_q;

endmodule

// File: rtl/ivtmr_top.sv
module ivtmr_top
    import ivt_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int PRE_W = 11,
    parameter int TAP0  = 3,
    parameter int TAP1  = 7,
    parameter int TAP2  = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [1:0]       clk_sel,
    input  logic [CNT_W-1:0] match_val,
    input  logic             ff_clr,
    input  logic             ff_inv_en,
    input  logic             irq_sel,
    input  logic             cnv_req,
    output logic             irq_out,
    output logic             tmr_out,
    output logic [CNT_W-1:0] cnt_out
);
    logic tick;
    logic match;

    ivt_prescaler #(
        .PRE_W (PRE_W),
        .TAP0  (TAP0),
        .TAP1  (TAP1),
        .TAP2  (TAP2)
    ) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (clk_sel),
        .tick  (tick)
    );

    ivt_count_fsm #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick),
        .limit (match_val),
        .cnt   (cnt_out),
        .match (match)
    );

    ivt_toggle_ff u_tff (
        .clk    (clk),
        .rst_n  (rst_n),
        .match  (match),
        .clr    (ff_clr),
        .inv_en (ff_inv_en),
        .pin    (tmr_out)
    );

    ivt_irq_route u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .route     (irq_sel),
        .tmr_match (match),
        .conv_req  (cnv_req),
        .irq       (irq_out)
    );

endmodule

// File: rtl/ivt_checker.sv
module ivt_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             ff_clr,
    input logic             ff_inv_en,
    input logic             irq_sel,
    input logic             cnv_req,
    input logic             irq_out,
    input logic             tmr_out,
    input logic [CNT_W-1:0] cnt_out
);
    // R1: stopping forces the count to zero on the next clock
    a_r1_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_out == '0));

    // R11: the count only holds, steps by one, or returns to zero
    a_r11_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run)) |-> (cnt_out == $past(cnt_out) ||
                                 cnt_out == $past(cnt_out) + CNT_W'(1) ||
                                 cnt_out == '0));

    // R5: a timer request is one clock wide
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_sel && $past(!irq_sel) && irq_out) |=> !irq_out);

    // R6: converter route forwards the request one clock later
    a_r6_conv_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_sel && cnv_req) |=> irq_out);

    // R6: converter route blocks timer matches
    a_r6_timer_block: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_sel && !cnv_req) |=> !irq_out);

    // R8: clear shows on the pin two clocks later
    a_r8_clear_pin: assert property (@(posedge clk) disable iff (!rst_n)
        ff_clr |-> ##2 !tmr_out);

    // R9: without inversion or clear the pin holds
    a_r9_hold_pin: assert property (@(posedge clk) disable iff (!rst_n)
        (!ff_inv_en && !ff_clr) |-> ##2 $stable(tmr_out));

endmodule

bind ivtmr_top ivt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .ff_clr    (ff_clr),
    .ff_inv_en (ff_inv_en),
    .irq_sel   (irq_sel),
    .cnv_req   (cnv_req),
    .irq_out   (irq_out),
    .tmr_out   (tmr_out),
    .cnt_out   (cnt_out)
);

// File: tb/sim_ivtmr_top.sv
`timescale 1ns/1ps
module sim_ivtmr_top;
    localparam real CLK_PERIOD = 100.0;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run = 1'b0;
    logic [1:0] clk_sel = 2'd0;
    logic [7:0] match_val = 8'd1;
    logic       ff_clr = 1'b0;
    logic       ff_inv_en = 1'b0;
    logic       irq_sel = 1'b0;
    logic       cnv_req = 1'b0;
    logic       irq_out;
    logic       tmr_out;
    logic [7:0] cnt_out;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ivtmr_top u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .clk_sel   (clk_sel),
        .match_val (match_val),
        .ff_clr    (ff_clr),
        .ff_inv_en (ff_inv_en),
        .irq_sel   (irq_sel),
        .cnv_req   (cnv_req),
        .irq_out   (irq_out),
        .tmr_out   (tmr_out),
        .cnt_out   (cnt_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_irq(input int lim, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!irq_out && n < lim);
    endtask

    task automatic restart(input logic [1:0] sel, input logic [7:0] val);
        @(negedge clk);
        run = 1'b0;
        repeat (2) @(negedge clk);
        clk_sel   = sel;
        match_val = val;
        run       = 1'b1;
    endtask

    task automatic t_reset();
        chk(cnt_out == 8'd0, "R10 count in reset", cnt_out, 0);
        chk(irq_out == 1'b0, "R10 irq in reset", irq_out, 0);
        chk(tmr_out == 1'b0, "R10 pin in reset", tmr_out, 0);
    endtask

    task automatic t_period(input logic [1:0] sel, input logic [7:0] val,
                            input int exp, input string req);
        int n;
        restart(sel, val);
        wait_irq(3 * exp + 64, n);
        wait_irq(exp + 64, n);
        chk(n == exp, req, n, exp);
    endtask

    task automatic t_pulse_width();
        int n;
        restart(2'd0, 8'd4);
        wait_irq(200, n);
        @(negedge clk);
        chk(irq_out == 1'b0, "R5 pulse one clock wide", irq_out, 0);
    endtask

    task automatic t_max_count();
        int mx = 0;
        restart(2'd0, 8'd5);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (int'(cnt_out) > mx) mx = int'(cnt_out);
        end
        chk(mx == 4, "R11 largest count is value-1", mx, 4);
    endtask

    task automatic t_stop_restart();
        int n;
        int hits = 0;
        restart(2'd0, 8'd50);
        repeat (100) @(negedge clk);
        run = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(cnt_out == 8'd0, "R1 stop clears count", cnt_out, 0);
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (irq_out || cnt_out != 8'd0) hits++;
        end
        chk(hits == 0, "R1 no counting while stopped", hits, 0);
        run = 1'b1;
        wait_irq(1000, n);
        chk(n >= 392 && n <= 404, "R1 restart counts from zero", n, 400);
    endtask

    task automatic t_no_strobe();
        int hits = 0;
        restart(2'd3, 8'd1);
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (irq_out || cnt_out != 8'd0) hits++;
        end
        chk(hits == 0, "R2 select 3 gives no strobes", hits, 0);
    endtask

    task automatic t_route();
        int hits = 0;
        restart(2'd0, 8'd1);
        irq_sel = 1'b1;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (irq_out) hits++;
        end
        chk(hits == 0, "R6 timer blocked on converter route", hits, 0);
        cnv_req = 1'b1;
        @(negedge clk);
        cnv_req = 1'b0;
        chk(irq_out == 1'b1, "R6 converter request forwarded", irq_out, 1);
        @(negedge clk);
        chk(irq_out == 1'b0, "R6 converter pulse ends", irq_out, 0);
        run = 1'b0;
        irq_sel = 1'b0;
        repeat (3) @(negedge clk);
        cnv_req = 1'b1;
        @(negedge clk);
        cnv_req = 1'b0;
        chk(irq_out == 1'b0, "R6 converter blocked on timer route", irq_out, 0);
    endtask

    task automatic t_square();
        int n;
        int hi = 0;
        int lo = 0;
        ff_inv_en = 1'b1;
        restart(2'd0, 8'd3);
        wait_irq(200, n);
        n = 0;
        while (tmr_out && n < 200) begin @(negedge clk); n++; end
        n = 0;
        while (!tmr_out && n < 200) begin @(negedge clk); n++; end
        while (tmr_out && hi < 200) begin @(negedge clk); hi++; end
        while (!tmr_out && lo < 200) begin @(negedge clk); lo++; end
        chk(hi == 24, "R7 high time", hi, 24);
        chk(lo == 24, "R7 low time", lo, 24);
    endtask

    task automatic t_no_invert();
        int changes = 0;
        logic v;
        ff_inv_en = 1'b0;
        restart(2'd0, 8'd1);
        repeat (4) @(negedge clk);
        v = tmr_out;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (tmr_out != v) changes++;
        end
        chk(changes == 0, "R9 pin holds without inversion", changes, 0);
    endtask

    task automatic t_clear_priority();
        int n;
        ff_inv_en = 1'b0;
        restart(2'd0, 8'd1);
        wait_irq(200, n);
        ff_clr    = 1'b1;
        ff_inv_en = 1'b1;
        @(negedge clk);
        ff_clr = 1'b0;
        @(negedge clk);
        chk(tmr_out == 1'b0, "R8 clear forces zero", tmr_out, 0);
        repeat (5) @(negedge clk);
        ff_clr = 1'b1;
        @(negedge clk);
        ff_clr = 1'b0;
        @(negedge clk);
        chk(tmr_out == 1'b0, "R8 clear wins over match", tmr_out, 0);
        repeat (8) @(negedge clk);
        chk(tmr_out == 1'b1, "R8 inversion resumes after clear", tmr_out, 1);
        ff_inv_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_period(2'd0, 8'd50, 400, "R3 value 50 at /8");
        t_period(2'd1, 8'd3, 384, "R2 value 3 at /128");
        t_period(2'd2, 8'd2, 4096, "R2 value 2 at /2048");
        t_period(2'd0, 8'd1, 8, "R3 value 1 at /8");
        t_period(2'd0, 8'd0, 2048, "R4 value 0 means 256");
        t_pulse_width();
        t_max_count();
        t_stop_restart();
        t_no_strobe();
        t_route();
        t_square();
        t_no_invert();
        t_clear_priority();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule